// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits behind a three-channel video digitiser. On every pixel clock it receives one sample per colour channel, each with an out-of-range flag, and places the registered result on one or two output ports. In single-port mode every pixel appears on port A one cycle after it is taken, and port B is held at zero. In dual-port mode consecutive pixels alternate between the ports, so each port runs at half the pixel rate. A select bit decides which port carries the odd pixels. A timing bit chooses between two port timings: synchronous, where a whole pixel pair is presented on one edge, or interleaved, where the ports update one pixel clock apart.

Horizontal-sync and clamp pulses can blank the samples to zero, flags included. The mode bits are shadowed and only reloaded while horizontal sync is active, so a video line is never split between two modes. Pixel parity restarts at each sync pulse, which makes the first pixel after sync the odd pixel. An output-disable bit drops the output-enable signals for the data and clock pin groups.

Top module: `pix_pair_demux`

## Requirements
- R1: While reset is asserted, all port data and flags read zero, both output enables read 0, and the shadowed mode is single-port with blanking off.
- R2: With single-port mode shadowed, port A carries the sample taken on the previous clock edge, and port B data and flags read zero.
- R3: In dual-port mode the sample taken in the first cycle after a sync-high cycle is odd, and parity then alternates. When the odd-on-A bit is 1, odd pixels go to port A and even pixels to port B. When it is 0, the assignment is reversed.
- R4: In dual synchronous mode (shift bit 0), the odd sample is held internally. On the edge that takes the following even sample, both ports update together. Otherwise they keep their values.
- R5: In dual interleaved mode (shift bit 1), the port owning a pixel updates on the edge that takes that pixel, and the other port keeps its value.
- R6: In dual-port mode, out_clk reads 1 in the cycle after an even sample is taken and 0 in the cycle after an odd sample. In single-port mode, out_clk follows the pixel clock.
- R7: With blanking shadowed on, a sample taken while hsync or clamp is 1 is replaced by zero in its data and its flags before routing.
- R8: With blanking shadowed off, samples taken during hsync or clamp pass through unchanged.
- R9: The mode inputs (dual, odd-on-A, shift, blank) are loaded into the shadow only on edges where hsync is 1. A change made without hsync has no effect on routing.
- R10: oe_data and oe_clk both equal the inverse of cfg_disable as sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_pix | input | NUM_CH*CH_W (24) | Channel samples, channel 0 in the low bits |
| in_ovr | input | NUM_CH (3) | Out-of-range flag per channel |
| hsync | input | 1 | Horizontal-sync pulse, active high |
| clamp | input | 1 | Clamp pulse, active high |
| cfg_dual | input | 1 | 1 = two ports, 0 = port A only |
| cfg_odd_a | input | 1 | 1 = odd pixels on port A |
| cfg_shift | input | 1 | 1 = interleaved port timing, 0 = synchronous |
| cfg_blank | input | 1 | 1 = zero samples during hsync/clamp |
| cfg_disable | input | 1 | 1 = drop output enables |
| port_a_pix | output | NUM_CH*CH_W (24) | Port A data |
| port_a_ovr | output | NUM_CH (3) | Port A flags |
| port_b_pix | output | NUM_CH*CH_W (24) | Port B data |
| port_b_ovr | output | NUM_CH (3) | Port B flags |
| out_clk | output | 1 | Output clock |
| oe_data | output | 1 | Output enable for data pins |
| oe_clk | output | 1 | Output enable for the clock pin |

## Verification
A parity register that drifts by one pixel swaps the port roles. In synchronous mode it also pairs an even pixel with the wrong odd pixel, and this shows at the ports within two cycles of the first line after sync, together with an inverted out_clk. A stale mode shadow shows as port B data appearing, or staying at zero, on the first cycle after sync. A blanking fault shows as a nonzero sample or flag on the cycle after a pulse. The reference model compares every output on every cycle, so each of these faults is caught at its first visible cycle.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
   typedef struct packed {
      logic dual;
      logic odd_a;
      logic shift;
      logic blank;
   } pdm_mode_t;

   localparam pdm_mode_t PDM_MODE_RESET = '{dual: 1'b0, odd_a: 1'b0, shift: 1'b0, blank: 1'b0};
endpackage

// File: rtl/pdm_mode_shadow.sv
module pdm_mode_shadow
   import pdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hsync,
   input  pdm_mode_t mode_in,
   output pdm_mode_t mode_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     mode_q <= PDM_MODE_RESET;
      else if (hsync) mode_q <= mode_in;
   end
endmodule

// File: rtl/pdm_parity.sv
module pdm_parity (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync,
   output logic is_odd
);
   logic next_even_q;

   assign is_odd = hsync | ~next_even_q;

   always_ff @(posedge clk) begin
      if (!rst_n) next_even_q <= 1'b0;
      else        next_even_q <= ~hsync & is_odd;
   end
endmodule

// File: rtl/pdm_router.sv
module pdm_router #(
   parameter int PIX_W = 24,
   parameter int OVR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dual,
   input  logic             odd_a,
   input  logic             shift,
   input  logic             is_odd,
   input  logic [PIX_W-1:0] samp_pix,
   input  logic [OVR_W-1:0] samp_ovr,
   output logic [PIX_W-1:0] a_pix,
   output logic [OVR_W-1:0] a_ovr,
   output logic [PIX_W-1:0] b_pix,
   output logic [OVR_W-1:0] b_ovr,
   output logic             clk_q
);
   localparam int LANE_W = PIX_W + OVR_W;

   logic [LANE_W-1:0] samp, hold_q, hold_d, a_q, a_d, b_q, b_d;
   logic              clk_d;

   assign samp = {samp_ovr, samp_pix};

   always_comb begin
      a_d    = a_q;
      b_d    = b_q;
      hold_d = hold_q;
      clk_d  = clk_q;
      if (!dual) begin
         a_d   = samp;
         b_d   = '0;
         clk_d = 1'b0;
      end else begin
         clk_d = ~is_odd;
         if (shift) begin
            if (is_odd == odd_a) a_d = samp;
            else                 b_d = samp;
         end else if (is_odd) begin
            hold_d = samp;
         end else if (odd_a) begin
            a_d = hold_q;
            b_d = samp;
         end else begin
            a_d = samp;
            b_d = hold_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         hold_q <= '0;
         clk_q  <= 1'b0;
      end else begin
         a_q    <= a_d;
         b_q    <= b_d;
         hold_q <= hold_d;
         clk_q  <= clk_d;
      end
   end

   assign {a_ovr, a_pix} = a_q;
   assign {b_ovr, b_pix} = b_q;
endmodule

// File: rtl/pix_pair_demux.sv
module pix_pair_demux
   import pdm_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CH_W   = 8,
   localparam int PIX_W = NUM_CH * CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic [NUM_CH-1:0] in_ovr,
   input  logic              hsync,
   input  logic              clamp,
   input  logic              cfg_dual,
   input  logic              cfg_odd_a,
   input  logic              cfg_shift,
   input  logic              cfg_blank,
   input  logic              cfg_disable,
   output logic [PIX_W-1:0]  port_a_pix,
   output logic [NUM_CH-1:0] port_a_ovr,
   output logic [PIX_W-1:0]  port_b_pix,
   output logic [NUM_CH-1:0] port_b_ovr,
   output logic              out_clk,
   output logic              oe_data,
   output logic              oe_clk
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("pix_pair_demux: NUM_CH must be at least 1");
   end
   if (CH_W < 1 || CH_W > 16) begin : g_bad_w
      $error("pix_pair_demux: CH_W must lie in 1..16");
   end

   pdm_mode_t         mode_in, mode_q;
   logic              act_dual, act_odd_a, act_shift, act_blank;
   logic              is_odd, blank_now, clk_q, oe_q;
   logic [PIX_W-1:0]  samp_pix;
   logic [NUM_CH-1:0] samp_ovr;

   assign mode_in = '{dual: cfg_dual, odd_a: cfg_odd_a, shift: cfg_shift, blank: cfg_blank};

   pdm_mode_shadow i_shadow (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .mode_in(mode_in), .mode_q(mode_q)
   );

   assign act_dual  = mode_q.dual;
   assign act_odd_a = mode_q.odd_a;
   assign act_shift = mode_q.shift;
   assign act_blank = mode_q.blank;

   pdm_parity i_parity (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .is_odd(is_odd)
   );

   assign blank_now = act_blank & (hsync | clamp);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      assign samp_pix[g*CH_W +: CH_W] = blank_now ? '0 : in_pix[g*CH_W +: CH_W];
      assign samp_ovr[g]              = ~blank_now & in_ovr[g];
   end

   pdm_router #(.PIX_W(PIX_W), .OVR_W(NUM_CH)) i_router (
      .clk(clk), .rst_n(rst_n),
      .dual(act_dual), .odd_a(act_odd_a), .shift(act_shift), .is_odd(is_odd),
      .samp_pix(samp_pix), .samp_ovr(samp_ovr),
      .a_pix(port_a_pix), .a_ovr(port_a_ovr),
      .b_pix(port_b_pix), .b_ovr(port_b_ovr),
      .clk_q(clk_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= ~cfg_disable;
   end

   assign out_clk = act_dual ? clk_q : clk;
   assign oe_data = oe_q;
   assign oe_clk  = oe_q;
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker #(
   parameter int PIX_W = 24,
   parameter int OVR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hsync,
   input logic             clamp,
   input logic             act_dual,
   input logic             act_blank,
   input logic             cfg_disable,
   input logic [PIX_W-1:0] in_pix,
   input logic [PIX_W-1:0] port_a_pix,
   input logic [OVR_W-1:0] port_a_ovr,
   input logic [PIX_W-1:0] port_b_pix,
   input logic [OVR_W-1:0] port_b_ovr,
   input logic             oe_data,
   input logic             oe_clk
);
   assert_single_b_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !act_dual |=> (port_b_pix == '0 && port_b_ovr == '0));

   assert_single_a_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_dual && !(act_blank && (hsync || clamp))) |=> port_a_pix == $past(in_pix));

   assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_dual && act_blank && (hsync || clamp)) |=> (port_a_pix == '0 && port_a_ovr == '0));

   assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync |=> ($stable(act_dual) && $stable(act_blank)));

   assert_oe_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (oe_data == !$past(cfg_disable) && oe_clk == oe_data));
endmodule

bind pix_pair_demux pdm_checker #(.PIX_W(PIX_W), .OVR_W(NUM_CH)) i_pdm_checker (
   .clk(clk), .rst_n(rst_n), .hsync(hsync), .clamp(clamp),
   .act_dual(act_dual), .act_blank(act_blank), .cfg_disable(cfg_disable),
   .in_pix(in_pix), .port_a_pix(port_a_pix), .port_a_ovr(port_a_ovr),
   .port_b_pix(port_b_pix), .port_b_ovr(port_b_ovr),
   .oe_data(oe_data), .oe_clk(oe_clk)
);

// File: tb/test_pix_pair_demux.sv
`timescale 1ns/1ps
module test_pix_pair_demux;
   localparam int NUM_CH = 3;
   localparam int CH_W   = 8;
   localparam int PIX_W  = NUM_CH * CH_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PIX_W-1:0]  in_pix = '0;
   logic [NUM_CH-1:0] in_ovr = '0;
   logic hsync = 0, clamp = 0;
   logic cfg_dual = 0, cfg_odd_a = 0, cfg_shift = 0, cfg_blank = 0, cfg_disable = 0;
   logic [PIX_W-1:0]  port_a_pix, port_b_pix;
   logic [NUM_CH-1:0] port_a_ovr, port_b_ovr;
   logic out_clk, oe_data, oe_clk;

   always #10 clk = ~clk;

   pix_pair_demux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_pix_pair_demux (
      .clk(clk), .rst_n(rst_n), .in_pix(in_pix), .in_ovr(in_ovr),
      .hsync(hsync), .clamp(clamp),
      .cfg_dual(cfg_dual), .cfg_odd_a(cfg_odd_a), .cfg_shift(cfg_shift),
      .cfg_blank(cfg_blank), .cfg_disable(cfg_disable),
      .port_a_pix(port_a_pix), .port_a_ovr(port_a_ovr),
      .port_b_pix(port_b_pix), .port_b_ovr(port_b_ovr),
      .out_clk(out_clk), .oe_data(oe_data), .oe_clk(oe_clk)
   );

   // behavioural reference
   logic m_dual, m_odda, m_shift, m_blank, m_ph, m_clkq, m_oe;
   logic [PIX_W+NUM_CH-1:0] m_a, m_b, m_hold, s;
   int vectors = 0, errors = 0, cycles = 0;
   string tag = "R1";
   bit done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_dual, m_odda, m_shift, m_blank, m_ph, m_clkq, m_oe} = '0;
         m_a = '0; m_b = '0; m_hold = '0;
      end else begin
         automatic bit bl  = m_blank && (hsync || clamp);
         automatic bit odd = hsync || !m_ph;
         s = bl ? '0 : {in_ovr, in_pix};
         if (!m_dual) begin
            m_a = s; m_b = '0; m_clkq = 0;
         end else begin
            m_clkq = !odd;
            if (m_shift) begin
               if (odd == m_odda) m_a = s; else m_b = s;
            end else if (odd) m_hold = s;
            else if (m_odda) begin m_a = m_hold; m_b = s; end
            else begin m_b = m_hold; m_a = s; end
         end
         m_ph = !hsync && odd;
         if (hsync) {m_dual, m_odda, m_shift, m_blank} = {cfg_dual, cfg_odd_a, cfg_shift, cfg_blank};
         m_oe = !cfg_disable;
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         chk(tag, "port_a_pix", port_a_pix, m_a[PIX_W-1:0]);
         chk(tag, "port_a_ovr", port_a_ovr, m_a[PIX_W +: NUM_CH]);
         chk(m_dual ? tag : "R2", "port_b_pix", port_b_pix, m_b[PIX_W-1:0]);
         chk(m_dual ? tag : "R2", "port_b_ovr", port_b_ovr, m_b[PIX_W +: NUM_CH]);
         chk("R6", "out_clk", out_clk, m_dual ? m_clkq : 1'b0);
         chk("R10", "oe_data", oe_data, m_oe);
         chk("R10", "oe_clk", oe_clk, m_oe);
      end
   end

   task automatic finish_run();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   task automatic step(input bit hs, input bit cl, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         hsync = hs; clamp = cl;
         in_pix = PIX_W'($urandom);
         in_ovr = NUM_CH'($urandom);
      end
   endtask

   task automatic set_mode(input bit d, input bit oa, input bit sh, input bit bk);
      @(negedge clk);
      {cfg_dual, cfg_odd_a, cfg_shift, cfg_blank} = {d, oa, sh, bk};
   endtask

   task automatic line(input int len);
      step(1, 0, 2);
      step(0, 0, len);
   endtask

   initial begin
      tag = "R1";
      step(0, 0, 4);
      @(negedge clk); rst_n = 1;
      tag = "R2";
      step(0, 0, 10);
      tag = "R9";                     // dual requested without sync: stays single
      set_mode(1, 1, 0, 0);
      step(0, 1, 6);
      tag = "R4";                     // R3 odd on A, synchronous pairs
      line(12);
      step(0, 0, 1); step(1, 0, 1); step(0, 0, 5);   // sync mid pair restarts parity (R3)
      tag = "R3";                     // odd on B
      set_mode(1, 0, 0, 0);
      line(9);
      tag = "R5";                     // interleaved, both port orders
      set_mode(1, 1, 1, 0);
      line(9);
      set_mode(1, 0, 1, 0);
      line(9);
      tag = "R7";                     // blanking in dual and single
      set_mode(1, 1, 0, 1);
      line(4); step(0, 1, 3); step(0, 0, 4);
      set_mode(0, 0, 0, 1);
      line(4); step(0, 1, 2); step(0, 0, 3); step(1, 1, 2); step(0, 0, 3);
      tag = "R8";                     // blanking off: pulses pass data
      set_mode(0, 0, 0, 0);
      line(3); step(0, 1, 4); step(1, 0, 3); step(0, 0, 2);
      tag = "R10";
      @(negedge clk); cfg_disable = 1;
      step(0, 0, 4);
      @(negedge clk); cfg_disable = 0;
      step(0, 0, 4);
      tag = "R6";
      set_mode(1, 1, 0, 0);
      line(10);
      @(negedge clk);
      finish_run();
   end
endmodule